// File: doc/BRIEF.md
# I2C Serial Byte-Memory Read Slave

This block is the slave side of a two-wire serial memory that holds 4096 bytes. It brings the clock and data lines into the system clock domain and finds bus Start and Stop conditions. It checks each control byte against a fixed device code and the strapped chip-select inputs. For a write transaction it takes a two-byte word address, which loads an address pointer that persists between transactions. Data is then served in three ways: a current-address read continues from where the last access left the pointer, a random read sets the pointer first with an address-only write and a repeated Start, and a sequential read keeps streaming bytes for as long as the master acknowledges.

The data line is open-drain and is modelled as `sda_oe`, which pulls the line low when high. The slave changes it only while the clock is low. The memory is a plain register array inside the block. Byte data writes are not part of this block.

The controller has ten states. IDLE waits for a Start. CTRL shifts in the control byte. CTRL_ACK drives the acknowledge for the control byte. ADDR_HI and ADDR_LO shift in the two address bytes, and AHI_ACK and ALO_ACK acknowledge them. WAIT ignores further write bytes. RD_DATA shifts a byte out. RD_ACK samples the master's answer. The transitions are:
- A Start in any state goes to CTRL.
- A Stop in any state goes to IDLE.
- In CTRL, a matching byte goes to CTRL_ACK and any other byte goes to IDLE.
- CTRL_ACK goes to RD_DATA when R/W is 1 and to ADDR_HI when it is 0.
- ADDR_HI → AHI_ACK → ADDR_LO → ALO_ACK → WAIT.
- RD_DATA goes to RD_ACK after 8 bits.
- RD_ACK goes to RD_DATA on a master ACK and to IDLE on a NACK.

Top module: `i2c_mem_reader`

## Requirements
- R1: A control byte is bits 7..4 = 1010, bits 3..1 = chip-select, and bit 0 = R/W, with 1 meaning read. The slave acknowledges it by holding SDA low during the 9th clock only when the chip-select field equals `chip_sel`. Any other control byte is not acknowledged, and the slave ignores the bus until the next Start, so its pointer is unchanged.
- R2: After a write control byte, the slave acknowledges two address bytes, high byte first. The pointer is loaded with the low 12 bits, and bits 7..4 of the high byte are ignored.
- R3: A repeated Start after the address bytes, followed by a read control byte, returns the byte stored at the loaded address.
- R4: Read data leaves MSB first, and `sda_oe` changes only while SCL is low.
- R5: A current-address read returns the byte at the address just after the last byte transmitted.
- R6: A master ACK after a data byte makes the slave send the next sequential byte. A NACK followed by a Stop ends the read, and SDA is released.
- R7: The pointer advances by one after each transmitted byte and wraps from 0xFFF to 0x000.
- R8: A Start seen in the middle of a byte abandons that byte and its bit count, and the slave then expects a fresh control byte.
- R9: In a write transaction, bytes after the two address bytes are not acknowledged and do not move the pointer.
- R10: During and after reset, SDA is released (`sda_oe` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_sel | input | 3 | Strapped chip-select value |
| scl_in | input | 1 | Serial clock from the bus |
| sda_in | input | 1 | Serial data level seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The hardest cases to reach from the pins are the pointer wrap in the middle of a sequential read and a Start that cuts a byte short. Both depend on state built up over earlier transactions. The bench first places the pointer at 0xFFD with an address-only write and a repeated Start. It then acknowledges across the top of the memory and follows with a current-address read. To test the abort, it sends half an address byte, breaks in with a repeated Start, and shows through a following read that the partial byte left the pointer untouched.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR_HI,
        ST_AHI_ACK,
        ST_ADDR_LO,
        ST_ALO_ACK,
        ST_WAIT,
        ST_RD_DATA,
        ST_RD_ACK
    } rd_state_t;

    localparam logic [3:0] DEV_CODE = 4'b1010;
    localparam int BYTE_W = 8;

endpackage

// File: rtl/i2cr_line_sync.sv
module i2cr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [1:0] raw;
    logic [1:0] pipe [STAGES];
    logic [1:0] prev;

    assign raw = {scl_in, sda_in};

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= 2'b11;
                    else        pipe[g] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= 2'b11;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 2'b11;
        else        prev <= pipe[STAGES-1];
    end

    assign scl_lvl   = pipe[STAGES-1][1];
    assign sda_lvl   = pipe[STAGES-1][0];
    assign scl_rise  = scl_lvl & ~prev[1];
    assign scl_fall  = ~scl_lvl & prev[1];
    assign start_evt = scl_lvl & prev[1] & prev[0] & ~sda_lvl;
    assign stop_evt  = scl_lvl & prev[1] & ~prev[0] & sda_lvl;
endmodule

// File: rtl/i2cr_byte_mem.sv
module i2cr_byte_mem #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/i2c_mem_reader.sv
module i2c_mem_reader #(
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] chip_sel,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe
);
    import i2cr_pkg::*;

    localparam int CNT_W = 4;

    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

    rd_state_t          state, state_d;
    logic [CNT_W-1:0]   bit_cnt, cnt_d;
    logic [BYTE_W-1:0]  shreg, shreg_d;
    logic [BYTE_W-1:0]  addr_hi, hi_d;
    logic [ADDR_W-1:0]  ptr, ptr_d;
    logic               oe_d;
    logic               mack, mack_d;
    logic [BYTE_W-1:0]  rd_data;
    logic [2*BYTE_W-1:0] addr_full;
    logic               byte_in;

    i2cr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_s), .sda_lvl(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
    );

    i2cr_byte_mem #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
        .rd_addr(ptr), .rd_data(rd_data)
    );

    assign addr_full = {addr_hi, shreg};
    assign byte_in   = scl_fall && (bit_cnt == CNT_W'(BYTE_W));

    always_comb begin
        state_d = state;
        cnt_d   = bit_cnt;
        shreg_d = shreg;
        hi_d    = addr_hi;
        ptr_d   = ptr;
        oe_d    = sda_oe;
        mack_d  = mack;
        if (start_evt) begin
            state_d = ST_CTRL;
            cnt_d   = '0;
            oe_d    = 1'b0;
        end else if (stop_evt) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            oe_d    = 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_CTRL, ST_ADDR_HI, ST_ADDR_LO, ST_WAIT: begin
                    if (scl_rise) begin
                        shreg_d = {shreg[BYTE_W-2:0], sda_s};
                        cnt_d   = bit_cnt + 1'b1;
                    end else if (byte_in) begin
                        cnt_d = '0;
                        if (state == ST_CTRL) begin
                            if (shreg[7:1] == {DEV_CODE, chip_sel}) begin
                                state_d = ST_CTRL_ACK;
                                oe_d    = 1'b1;
                            end else begin
                                state_d = ST_IDLE;
                            end
                        end else if (state == ST_ADDR_HI) begin
                            hi_d    = shreg;
                            state_d = ST_AHI_ACK;
                            oe_d    = 1'b1;
                        end else if (state == ST_ADDR_LO) begin
                            ptr_d   = addr_full[ADDR_W-1:0];
                            state_d = ST_ALO_ACK;
                            oe_d    = 1'b1;
                        end
                    end
                end
                ST_CTRL_ACK: begin
                    if (scl_fall) begin
                        cnt_d = '0;
                        if (shreg[0]) begin
                            state_d = ST_RD_DATA;
                            shreg_d = rd_data;
                            oe_d    = ~rd_data[BYTE_W-1];
                        end else begin
                            state_d = ST_ADDR_HI;
                            oe_d    = 1'b0;
                        end
                    end
                end
                ST_AHI_ACK: begin
                    if (scl_fall) begin
                        state_d = ST_ADDR_LO;
                        oe_d    = 1'b0;
                    end
                end
                ST_ALO_ACK: begin
                    if (scl_fall) begin
                        state_d = ST_WAIT;
                        oe_d    = 1'b0;
                    end
                end
                ST_RD_DATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                            state_d = ST_RD_ACK;
                            cnt_d   = '0;
                            oe_d    = 1'b0;
                            ptr_d   = ptr + 1'b1;
                        end else begin
                            cnt_d   = bit_cnt + 1'b1;
                            shreg_d = {shreg[BYTE_W-2:0], 1'b0};
                            oe_d    = ~shreg[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        mack_d = ~sda_s;
                    end else if (scl_fall) begin
                        if (mack) begin
                            state_d = ST_RD_DATA;
                            cnt_d   = '0;
                            shreg_d = rd_data;
                            oe_d    = ~rd_data[BYTE_W-1];
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            addr_hi <= '0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
            mack    <= 1'b0;
        end else begin
            bit_cnt <= cnt_d;
            shreg   <= shreg_d;
            addr_hi <= hi_d;
            ptr     <= ptr_d;
            sda_oe  <= oe_d;
            mack    <= mack_d;
        end
    end
endmodule

// File: rtl/i2cr_checker.sv
module i2cr_checker
    import i2cr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              start_evt,
    input rd_state_t         state,
    input logic [3:0]        bit_cnt,
    input logic [7:0]        shreg,
    input logic [2:0]        chip_sel,
    input logic [ADDR_W-1:0] ptr,
    input logic              sda_oe
);
    a_r4_sda_moves_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

    a_r8_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_evt) |-> (state == ST_CTRL && bit_cnt == 4'd0 && !sda_oe));

    a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_RD_DATA && state == ST_RD_ACK) |-> (ptr == $past(ptr) + 1'b1));

    a_r1_ack_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_CTRL && state == ST_CTRL_ACK)
            |-> ($past(shreg[7:1]) == {DEV_CODE, $past(chip_sel)}));
endmodule

bind i2c_mem_reader i2cr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_evt(start_evt),
    .state(state), .bit_cnt(bit_cnt), .shreg(shreg), .chip_sel(chip_sel),
    .ptr(ptr), .sda_oe(sda_oe)
);

// File: tb/i2c_mem_reader_tb.sv
module i2c_mem_reader_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_bus;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] CW = 8'hAA;
    localparam logic [7:0] CR = 8'hAB;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct { logic [7:0] val; string tag; } exp_t;
    exp_t exp_q[$];
    logic [7:0] got_byte;
    event got_ev;

    assign sda_bus = m_sda & ~sda_oe;

    always #10 clk = ~clk;

    i2c_mem_reader u_dut (
        .clk(clk), .rst_n(rst_n), .chip_sel(STRAP),
        .scl_in(scl), .sda_in(sda_bus), .sda_oe(sda_oe)
    );

    function automatic logic [7:0] pat(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic q();
        repeat (4) @(negedge clk);
    endtask

    task automatic m_start();
        q(); m_sda = 1'b1; q(); scl = 1'b1; q(); m_sda = 1'b0; q(); scl = 1'b0;
    endtask

    task automatic m_stop();
        q(); m_sda = 1'b0; q(); scl = 1'b1; q(); m_sda = 1'b1; q();
    endtask

    task automatic m_wbit(input logic b);
        q(); m_sda = b; q(); scl = 1'b1; q(); q(); scl = 1'b0;
    endtask

    task automatic m_rbit(output logic b);
        q(); m_sda = 1'b1; q(); scl = 1'b1; q(); b = sda_bus; q(); scl = 1'b0;
    endtask

    task automatic m_wbyte(input logic [7:0] v, input bit exp_ack, input string tag);
        logic b;
        for (int i = 7; i >= 0; i--) m_wbit(v[i]);
        m_rbit(b);
        chk((!b) == exp_ack, tag, int'(!b), int'(exp_ack));
    endtask

    task automatic push_exp(input logic [11:0] a, input string tag);
        exp_t e;
        e.val = pat(a);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic m_rbyte(input bit give_ack);
        logic b;
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) begin
            m_rbit(b);
            v[i] = b;
        end
        got_byte = v;
        -> got_ev;
        m_wbit(!give_ack);
    endtask

    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string tag);
        m_start();
        m_wbyte(CW, 1'b1, {tag, " ctrl write ack (R1)"});
        m_wbyte(hi, 1'b1, {tag, " addr hi ack (R2)"});
        m_wbyte(lo, 1'b1, {tag, " addr lo ack (R2)"});
    endtask

    task automatic cur_read(input logic [11:0] a, input string tag);
        m_start();
        m_wbyte(CR, 1'b1, {tag, " ctrl read ack (R1)"});
        push_exp(a, tag);
        m_rbyte(1'b0);
        m_stop();
        q();
        chk(sda_oe == 1'b0, {tag, " released after stop (R6)"}, int'(sda_oe), 0);
    endtask

    // monitor: compares each byte the master assembles against the scoreboard
    initial begin
        forever begin
            @(got_ev);
            if (exp_q.size() == 0) begin
                chk(1'b0, "unexpected byte", int'(got_byte), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(got_byte == e.val, e.tag, int'(got_byte), int'(e.val));
            end
        end
    end

    initial begin
        #1;
        for (int i = 0; i < 4096; i++) u_dut.u_mem.mem[i] = pat(12'(i));
        repeat (3) @(negedge clk);
        chk(sda_oe == 1'b0, "R10 released in reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sda_oe == 1'b0, "R10 released after reset", int'(sda_oe), 0);

        // R2/R3: high nibble of hi byte ignored -> 0x123
        set_addr(8'hF1, 8'h23, "R3 random");
        m_start();
        m_wbyte(CR, 1'b1, "R3 read ctrl ack");
        push_exp(12'h123, "R3 random read data, MSB first R4");
        m_rbyte(1'b0);
        m_stop();

        // R5: current-address continues after 0x123
        cur_read(12'h124, "R5 current read");

        // R6/R7: sequential across the top of memory
        set_addr(8'h0F, 8'hFD, "R7 seq");
        m_start();
        m_wbyte(CR, 1'b1, "R6 read ctrl ack");
        push_exp(12'hFFD, "R6 seq byte0");
        m_rbyte(1'b1);
        push_exp(12'hFFE, "R6 seq byte1");
        m_rbyte(1'b1);
        push_exp(12'hFFF, "R7 seq top byte");
        m_rbyte(1'b1);
        push_exp(12'h000, "R7 wrapped byte");
        m_rbyte(1'b0);
        m_stop();
        cur_read(12'h001, "R7 pointer after wrap");

        // R1: chip-select mismatch ignored, pointer unchanged
        m_start();
        m_wbyte(8'hAC, 1'b0, "R1 mismatch not acked");
        m_stop();
        cur_read(12'h002, "R1 pointer kept after mismatch");

        // R9: data byte after the address is not acknowledged
        set_addr(8'h02, 8'h00, "R9 write");
        m_wbyte(8'h77, 1'b0, "R9 data byte not acked");
        m_stop();
        cur_read(12'h200, "R9 pointer unchanged by data byte");

        // R8: Start in the middle of an address byte
        m_start();
        m_wbyte(CW, 1'b1, "R8 ctrl write ack");
        for (int i = 0; i < 4; i++) m_wbit(1'b0);
        cur_read(12'h201, "R8 read after aborted byte");

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule